// File: doc/BRIEF.md
# Privileged Trap-Return State Unit

This unit carries out the two trap-return operations of a core that has user, supervisor and machine privilege plus an optional hypervisor extension. The core presents a one-cycle request with the kind of return (supervisor return or machine return), the current privilege and virtualization state, a packed view of the status and hypervisor-status bits it owns, both saved exception PCs, and flags for the compressed-instruction extension, the hypervisor extension and memory protection. The unit checks whether the return is allowed. It then either reports one exception with a cause code, or produces the updated status fields, the new privilege, the new virtualization bit and the PC to redirect to.

The control is a three-state machine. In `S_IDLE` the unit waits for a request. The transition `IDLE_TO_COMMIT` is taken when every check passes. The transition `IDLE_TO_TRAP` is taken when any check fails. Both `S_COMMIT` and `S_TRAP` last one cycle and always return to `S_IDLE` (`COMMIT_TO_IDLE`, `TRAP_TO_IDLE`). A request that arrives outside `S_IDLE` is not accepted. The result outputs are registered. They are loaded only on a commit and hold their values until the next commit.

The checks are taken in a fixed priority, and the first one that fails decides the cause:
1. Privilege level.
2. PC alignment.
3. The trap-supervisor-return bit for a supervisor return, or the protection-rule check for a machine return.
4. The virtual trap-supervisor-return bit.

Top module: `trap_ret_unit`

## Requirements
- R1: A machine return with current privilege other than machine (3), or a supervisor return with current privilege user (0), raises exception cause 2 (illegal instruction). This check has the highest priority.
- R2: If `has_c` is 0 and bit 1 or bit 0 of the return PC is set, the unit raises cause 0 (misaligned instruction address). The return PC is `sepc` for a supervisor return and `mepc` for a machine return. This check ranks second.
- R3: A supervisor return with status bit 8 (trap-supervisor-return) set and current privilege not machine raises cause 2. This check ranks third.
- R4: A supervisor return with `has_h`=1, `cur_virt`=1 and hypervisor-status bit 1 (virtual trap-supervisor-return) set raises cause 22 (virtual instruction). This check ranks lowest.
- R5: A committed machine return has these effects:
  - status bit 1 (MIE) takes the old bit 3 (MPIE);
  - bit 3 is set to 1;
  - bits 6:5 (MPP) become 0;
  - bit 7 (MPV) is cleared;
  - `new_priv` equals the old MPP;
  - `redirect_pc` equals `mepc`.
- R6: On a committed machine return with `has_h`=1, `new_virt` equals the old MPV. With `has_h`=0, `new_virt` keeps `cur_virt`.
- R7: When `has_pmp`=1, `pmp_rules`=0 and the old MPP is not machine, a machine return raises cause 2. This check ranks third.
- R8: A committed supervisor return with `has_h`=1 and `cur_virt`=0 has these effects:
  - `new_priv` is the old status bit 4 (SPP; 0 is user, 1 is supervisor);
  - `new_virt` is the old hypervisor-status bit 0 (SPV);
  - SPV and SPP are cleared;
  - bit 0 (SIE) takes the old bit 2 (SPIE);
  - SPIE becomes 1.
- R9: Any other committed supervisor return has these effects:
  - SIE takes SPIE, SPIE becomes 1 and SPP becomes 0;
  - `new_priv` comes from the old SPP;
  - `new_virt` keeps `cur_virt`;
  - the hypervisor status is unchanged;
  - `redirect_pc` equals `sepc`.
- R10: `swap_pulse` is high for exactly the one `done` cycle of a commit whose restored virtualization bit (MPV in R6, SPV in R8) is 1. It is low at all other times.
- R11: A request sampled in `S_IDLE` produces, one cycle later, exactly one of `done` or `exc_valid` for one cycle. On an exception the result outputs keep their previous values.
- R12: After reset, the outputs are: `new_priv`=3, `new_virt`=0, status and hypervisor status 0, `redirect_pc` 0, `done`=0 and `exc_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Return request, one cycle |
| req_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_virt | input | 1 | Current virtualization bit |
| has_c | input | 1 | Compressed-instruction extension present |
| has_h | input | 1 | Hypervisor extension present |
| has_pmp | input | 1 | Memory protection supported |
| pmp_rules | input | PMP_CNT_W | Number of configured protection rules |
| status_in | input | 9 | Packed status bits (layout in R3, R5, R8) |
| hstat_in | input | 2 | Packed hypervisor status: bit 0 SPV, bit 1 virtual trap-supervisor-return |
| sepc | input | XLEN | Saved supervisor exception PC |
| mepc | input | XLEN | Saved machine exception PC |
| done | output | 1 | Commit strobe |
| exc_valid | output | 1 | Exception request strobe |
| exc_cause | output | 5 | Exception cause code |
| status_out | output | 9 | Updated status bits |
| hstat_out | output | 2 | Updated hypervisor status bits |
| new_priv | output | 2 | Privilege after return |
| new_virt | output | 1 | Virtualization bit after return |
| redirect_pc | output | XLEN | PC to resume at |
| swap_pulse | output | 1 | Request to swap hypervisor register banks |

## Verification
The bench builds the unit with `XLEN`=32 and `PMP_CNT_W`=4. This makes a rule count of zero as reachable as a non-zero count, and keeps the PC values short while still covering both low alignment bits. Directed scenarios cover each return path with and without the hypervisor extension. They place two failing conditions in the same request to confirm the priority order, and they issue a commit followed by a rejected return to show that the results hold.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

    localparam int ST_W    = 9;
    localparam int ST_SIE  = 0;
    localparam int ST_MIE  = 1;
    localparam int ST_SPIE = 2;
    localparam int ST_MPIE = 3;
    localparam int ST_SPP  = 4;
    localparam int ST_MPP0 = 5;
    localparam int ST_MPP1 = 6;
    localparam int ST_MPV  = 7;
    localparam int ST_TSR  = 8;

    localparam int HS_W    = 2;
    localparam int HS_SPV  = 0;
    localparam int HS_VTSR = 1;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_COMMIT = 2'd1,
        S_TRAP   = 2'd2
    } ret_state_e;
endpackage

// File: rtl/trap_ret_check.sv
module trap_ret_check
    import trap_ret_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int PMP_CNT_W = 4
) (
    input  logic                 is_mret,
    input  logic [1:0]           cur_priv,
    input  logic                 cur_virt,
    input  logic                 has_c,
    input  logic                 has_h,
    input  logic                 has_pmp,
    input  logic [PMP_CNT_W-1:0] pmp_rules,
    input  logic [ST_W-1:0]      status_in,
    input  logic [HS_W-1:0]      hstat_in,
    input  logic [XLEN-1:0]      ret_pc,
    output logic                 fault,
    output logic [CAUSE_W-1:0]   cause
);
    logic bad_priv, bad_align, bad_third, bad_virt;
    logic [1:0] old_mpp;

    always_comb begin
        old_mpp   = {status_in[ST_MPP1], status_in[ST_MPP0]};
        bad_priv  = is_mret ? (cur_priv != PRIV_M) : (cur_priv == PRIV_U);
        bad_align = !has_c && (ret_pc[1:0] != 2'b00);
        if (is_mret) begin
            bad_third = has_pmp && (pmp_rules == '0) && (old_mpp != PRIV_M);
            bad_virt  = 1'b0;
        end else begin
            bad_third = status_in[ST_TSR] && (cur_priv != PRIV_M);
            bad_virt  = has_h && cur_virt && hstat_in[HS_VTSR];
        end

        fault = 1'b1;
        cause = CAUSE_ILLEGAL;
        if (bad_priv) begin
            cause = CAUSE_ILLEGAL;
        end else if (bad_align) begin
            cause = CAUSE_MISALIGN;
        end else if (bad_third) begin
            cause = CAUSE_ILLEGAL;
        end else if (bad_virt) begin
            cause = CAUSE_VIRT;
        end else begin
            fault = 1'b0;
        end
    end
endmodule

// File: rtl/trap_ret_next.sv
module trap_ret_next
    import trap_ret_pkg::*;
(
    input  logic            is_mret,
    input  logic            cur_virt,
    input  logic            has_h,
    input  logic [ST_W-1:0] status_in,
    input  logic [HS_W-1:0] hstat_in,
    output logic [ST_W-1:0] status_nx,
    output logic [HS_W-1:0] hstat_nx,
    output logic [1:0]      priv_nx,
    output logic            virt_nx,
    output logic            swap_nx
);
    always_comb begin
        status_nx = status_in;
        hstat_nx  = hstat_in;
        virt_nx   = cur_virt;
        swap_nx   = 1'b0;
        if (is_mret) begin
            priv_nx              = {status_in[ST_MPP1], status_in[ST_MPP0]};
            status_nx[ST_MIE]    = status_in[ST_MPIE];
            status_nx[ST_MPIE]   = 1'b1;
            status_nx[ST_MPP0]   = 1'b0;
            status_nx[ST_MPP1]   = 1'b0;
            status_nx[ST_MPV]    = 1'b0;
            if (has_h) begin
                virt_nx = status_in[ST_MPV];
                swap_nx = status_in[ST_MPV];
            end
        end else begin
            priv_nx              = status_in[ST_SPP] ? PRIV_S : PRIV_U;
            status_nx[ST_SIE]    = status_in[ST_SPIE];
            status_nx[ST_SPIE]   = 1'b1;
            status_nx[ST_SPP]    = 1'b0;
            if (has_h && !cur_virt) begin
                virt_nx          = hstat_in[HS_SPV];
                swap_nx          = hstat_in[HS_SPV];
                hstat_nx[HS_SPV] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/trap_ret_unit.sv
module trap_ret_unit
    import trap_ret_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int PMP_CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_mret,
    input  logic [1:0]           cur_priv,
    input  logic                 cur_virt,
    input  logic                 has_c,
    input  logic                 has_h,
    input  logic                 has_pmp,
    input  logic [PMP_CNT_W-1:0] pmp_rules,
    input  logic [8:0]           status_in,
    input  logic [1:0]           hstat_in,
    input  logic [XLEN-1:0]      sepc,
    input  logic [XLEN-1:0]      mepc,
    output logic                 done,
    output logic                 exc_valid,
    output logic [4:0]           exc_cause,
    output logic [8:0]           status_out,
    output logic [1:0]           hstat_out,
    output logic [1:0]           new_priv,
    output logic                 new_virt,
    output logic [XLEN-1:0]      redirect_pc,
    output logic                 swap_pulse
);
    ret_state_e state, state_nx;

    logic                idle;
    logic [XLEN-1:0]     ret_pc;
    logic                chk_fault;
    logic [CAUSE_W-1:0]  chk_cause;
    logic [ST_W-1:0]     st_nx;
    logic [HS_W-1:0]     hs_nx;
    logic [1:0]          pr_nx;
    logic                vt_nx;
    logic                sw_nx;

    logic [ST_W-1:0]     r_status;
    logic [HS_W-1:0]     r_hstat;
    logic [1:0]          r_priv;
    logic                r_virt;
    logic [XLEN-1:0]     r_pc;
    logic [CAUSE_W-1:0]  r_cause;
    logic                r_swap;

    assign idle   = (state == S_IDLE);
    assign ret_pc = req_mret ? mepc : sepc;

    trap_ret_check #(.XLEN(XLEN), .PMP_CNT_W(PMP_CNT_W)) u_check (
        .is_mret   (req_mret),
        .cur_priv  (cur_priv),
        .cur_virt  (cur_virt),
        .has_c     (has_c),
        .has_h     (has_h),
        .has_pmp   (has_pmp),
        .pmp_rules (pmp_rules),
        .status_in (status_in),
        .hstat_in  (hstat_in),
        .ret_pc    (ret_pc),
        .fault     (chk_fault),
        .cause     (chk_cause)
    );

    trap_ret_next u_next (
        .is_mret   (req_mret),
        .cur_virt  (cur_virt),
        .has_h     (has_h),
        .status_in (status_in),
        .hstat_in  (hstat_in),
        .status_nx (st_nx),
        .hstat_nx  (hs_nx),
        .priv_nx   (pr_nx),
        .virt_nx   (vt_nx),
        .swap_nx   (sw_nx)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    state_nx = chk_fault ? S_TRAP : S_COMMIT;
                end
            end
            S_COMMIT: state_nx = S_IDLE;
            S_TRAP:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_status <= '0;
            r_hstat  <= '0;
            r_priv   <= PRIV_M;
            r_virt   <= 1'b0;
            r_pc     <= '0;
            r_cause  <= '0;
            r_swap   <= 1'b0;
        end else if (idle && req_valid) begin
            if (chk_fault) begin
                r_cause <= chk_cause;
            end else begin
                r_status <= st_nx;
                r_hstat  <= hs_nx;
                r_priv   <= pr_nx;
                r_virt   <= vt_nx;
                r_pc     <= ret_pc;
                r_swap   <= sw_nx;
            end
        end
    end

    always_comb begin
        done        = 1'b0;
        exc_valid   = 1'b0;
        swap_pulse  = 1'b0;
        unique case (state)
            S_IDLE:   ;
            S_COMMIT: begin
                done       = 1'b1;
                swap_pulse = r_swap;
            end
            S_TRAP:   exc_valid = 1'b1;
            default:  ;
        endcase
        exc_cause   = r_cause;
        status_out  = r_status;
        hstat_out   = r_hstat;
        new_priv    = r_priv;
        new_virt    = r_virt;
        redirect_pc = r_pc;
    end
endmodule

// File: rtl/trap_ret_chk.sv
module trap_ret_chk #(
    parameter int XLEN      = 32,
    parameter int PMP_CNT_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 idle,
    input logic                 req_valid,
    input logic                 req_mret,
    input logic [1:0]           cur_priv,
    input logic                 has_c,
    input logic                 done,
    input logic                 exc_valid,
    input logic [4:0]           exc_cause,
    input logic [8:0]           status_out,
    input logic [1:0]           new_priv,
    input logic                 new_virt,
    input logic [XLEN-1:0]      redirect_pc,
    input logic                 swap_pulse
);
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && exc_valid));

    p_trap_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> ($stable(status_out) && $stable(new_priv) && $stable(redirect_pc)));

    p_strobe_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || exc_valid) |=> !(done || exc_valid));

    p_swap_only_virt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> (done && new_virt));

    p_mret_priv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_valid && req_mret && cur_priv != 2'd3)
        |=> (exc_valid && exc_cause == 5'd2));

    p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_valid && !has_c) |=> (!done || redirect_pc[1:0] == 2'b00));

    p_mret_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_valid && req_mret)
        |=> (exc_valid || (status_out[3] && status_out[6:5] == 2'b00 && !status_out[7])));
endmodule

bind trap_ret_unit trap_ret_chk #(.XLEN(XLEN), .PMP_CNT_W(PMP_CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (idle),
    .req_valid   (req_valid),
    .req_mret    (req_mret),
    .cur_priv    (cur_priv),
    .has_c       (has_c),
    .done        (done),
    .exc_valid   (exc_valid),
    .exc_cause   (exc_cause),
    .status_out  (status_out),
    .new_priv    (new_priv),
    .new_virt    (new_virt),
    .redirect_pc (redirect_pc),
    .swap_pulse  (swap_pulse)
);

// File: tb/trap_ret_unit_test.sv
module trap_ret_unit_test;
    localparam int XLEN = 32;
    localparam int PW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_mret = 1'b0;
    logic [1:0]      cur_priv = 2'd3;
    logic            cur_virt = 1'b0;
    logic            has_c = 1'b1;
    logic            has_h = 1'b0;
    logic            has_pmp = 1'b0;
    logic [PW-1:0]   pmp_rules = '0;
    logic [8:0]      status_in = '0;
    logic [1:0]      hstat_in = '0;
    logic [XLEN-1:0] sepc = '0;
    logic [XLEN-1:0] mepc = '0;
    logic            done, exc_valid, new_virt, swap_pulse;
    logic [4:0]      exc_cause;
    logic [8:0]      status_out;
    logic [1:0]      hstat_out, new_priv;
    logic [XLEN-1:0] redirect_pc;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    trap_ret_unit #(.XLEN(XLEN), .PMP_CNT_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mret(req_mret),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .has_c(has_c), .has_h(has_h),
        .has_pmp(has_pmp), .pmp_rules(pmp_rules), .status_in(status_in),
        .hstat_in(hstat_in), .sepc(sepc), .mepc(mepc), .done(done),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .status_out(status_out),
        .hstat_out(hstat_out), .new_priv(new_priv), .new_virt(new_virt),
        .redirect_pc(redirect_pc), .swap_pulse(swap_pulse)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic mret, input logic [1:0] pr, input logic vt,
                         input logic [8:0] st, input logic [1:0] hs);
        @(negedge clk);
        req_valid = 1'b1;
        req_mret  = mret;
        cur_priv  = pr;
        cur_virt  = vt;
        status_in = st;
        hstat_in  = hs;
        @(posedge clk);
        #1;
    endtask

    task automatic release_req();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R11 strobes clear", {done, exc_valid, swap_pulse}, 3'b000);
    endtask

    task automatic expect_trap(input string tag, input logic [4:0] cause);
        chk({tag, " exc_valid"}, exc_valid, 1'b1);
        chk({tag, " done"}, done, 1'b0);
        chk({tag, " cause"}, exc_cause, cause);
    endtask

    task automatic t_reset();
        chk("R12 priv", new_priv, 2'd3);
        chk("R12 virt", new_virt, 1'b0);
        chk("R12 status", status_out, 9'd0);
        chk("R12 pc", redirect_pc, 0);
        chk("R12 strobes", {done, exc_valid}, 2'b00);
    endtask

    task automatic t_mret_basic();
        has_c = 1; has_h = 0; has_pmp = 0;
        mepc = 32'h0000_1230;
        // MPIE=1, MPP=S(1), MIE=0
        issue(1'b1, 2'd3, 1'b0, 9'b0_0010_1000, 2'b00);
        chk("R5 done", done, 1'b1);
        chk("R5 status", status_out, 9'b0_0000_1010);
        chk("R5 priv", new_priv, 2'd1);
        chk("R5 pc", redirect_pc, 32'h0000_1230);
        chk("R6 no-h virt", new_virt, 1'b0);
        chk("R10 no swap", swap_pulse, 1'b0);
        release_req();
    endtask

    task automatic t_mret_priv();
        issue(1'b1, 2'd1, 1'b0, 9'b0_0110_1000, 2'b00);
        expect_trap("R1 mret from S", 5'd2);
        release_req();
    endtask

    task automatic t_misalign();
        has_c = 0;
        mepc = 32'h0000_0102;
        issue(1'b1, 2'd3, 1'b0, 9'b0_0110_0000, 2'b00);
        expect_trap("R2 mret misaligned", 5'd0);
        release_req();
        has_c = 1;
        issue(1'b1, 2'd3, 1'b0, 9'b0_0110_0000, 2'b00);
        chk("R2 has_c allows odd pc", done, 1'b1);
        chk("R2 pc", redirect_pc, 32'h0000_0102);
        release_req();
    endtask

    task automatic t_pmp();
        has_pmp = 1; pmp_rules = '0; mepc = 32'h40;
        issue(1'b1, 2'd3, 1'b0, 9'b0_0000_1000, 2'b00);
        expect_trap("R7 no rules to U", 5'd2);
        release_req();
        issue(1'b1, 2'd3, 1'b0, 9'b0_0110_1000, 2'b00);
        chk("R7 no rules to M done", done, 1'b1);
        chk("R7 priv M", new_priv, 2'd3);
        release_req();
        pmp_rules = 4'd2;
        issue(1'b1, 2'd3, 1'b0, 9'b0_0000_1000, 2'b00);
        chk("R7 rules present", done, 1'b1);
        chk("R7 priv U", new_priv, 2'd0);
        release_req();
        has_pmp = 0;
    endtask

    task automatic t_mret_hyp();
        has_h = 1; mepc = 32'h80;
        // MPV=1, MPP=S, MPIE=0
        issue(1'b1, 2'd3, 1'b0, 9'b0_1010_0000, 2'b00);
        chk("R6 virt from MPV", new_virt, 1'b1);
        chk("R10 swap", swap_pulse, 1'b1);
        chk("R5 mpv cleared", status_out, 9'b0_0000_1000);
        release_req();
        has_h = 0;
    endtask

    task automatic t_sret_checks();
        sepc = 32'h0000_0201;
        has_c = 0;
        issue(1'b0, 2'd0, 1'b0, 9'd0, 2'b00);
        expect_trap("R1 sret from U over misalign", 5'd2);
        release_req();
        issue(1'b0, 2'd1, 1'b0, 9'b1_0000_0000, 2'b00);
        expect_trap("R2 misalign over TSR", 5'd0);
        release_req();
        has_c = 1;
        issue(1'b0, 2'd1, 1'b0, 9'b1_0000_0000, 2'b00);
        expect_trap("R3 TSR in S", 5'd2);
        release_req();
        issue(1'b0, 2'd3, 1'b0, 9'b1_0001_0000, 2'b00);
        chk("R3 TSR ignored in M", done, 1'b1);
        chk("R3 priv S", new_priv, 2'd1);
        release_req();
        has_h = 1;
        issue(1'b0, 2'd1, 1'b1, 9'd0, 2'b10);
        expect_trap("R4 VTSR", 5'd22);
        release_req();
        issue(1'b0, 2'd1, 1'b1, 9'b1_0000_0000, 2'b10);
        expect_trap("R3 TSR over VTSR", 5'd2);
        release_req();
        has_h = 0;
    endtask

    task automatic t_sret_plain();
        sepc = 32'h0000_0300;
        // SPP=1, SPIE=0, SIE=1
        issue(1'b0, 2'd1, 1'b0, 9'b0_0001_0001, 2'b11);
        chk("R9 status", status_out, 9'b0_0000_0100);
        chk("R9 priv", new_priv, 2'd1);
        chk("R9 hstat unchanged", hstat_out, 2'b11);
        chk("R9 pc", redirect_pc, 32'h0000_0300);
        release_req();
    endtask

    task automatic t_sret_hyp();
        has_h = 1;
        sepc = 32'h0000_0400;
        // SPP=0, SPIE=1, SPV=1
        issue(1'b0, 2'd1, 1'b0, 9'b0_0000_0100, 2'b01);
        chk("R8 virt", new_virt, 1'b1);
        chk("R8 swap", swap_pulse, 1'b1);
        chk("R8 status", status_out, 9'b0_0000_0101);
        chk("R8 hstat", hstat_out, 2'b00);
        chk("R8 priv", new_priv, 2'd0);
        release_req();
        issue(1'b0, 2'd1, 1'b1, 9'b0_0001_0000, 2'b01);
        chk("R9 virt kept", new_virt, 1'b1);
        chk("R10 no swap virtualized", swap_pulse, 1'b0);
        chk("R9 hstat kept", hstat_out, 2'b01);
        release_req();
        has_h = 0;
    endtask

    task automatic t_hold_on_trap();
        logic [8:0] st_prev;
        logic [XLEN-1:0] pc_prev;
        st_prev = status_out;
        pc_prev = redirect_pc;
        sepc = 32'h0000_0500;
        issue(1'b0, 2'd0, 1'b0, 9'b0_0001_0100, 2'b00);
        expect_trap("R11 trap", 5'd2);
        chk("R11 status held", status_out, st_prev);
        chk("R11 pc held", redirect_pc, pc_prev);
        release_req();
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_mret_basic();
        t_mret_priv();
        t_misalign();
        t_pmp();
        t_mret_hyp();
        t_sret_checks();
        t_sret_plain();
        t_sret_hyp();
        t_hold_on_trap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule